// File: doc/BRIEF.md
# Transaction-Layer Header Builder and Completion Decoder

This block sits between a request source and a 32-bit transaction-layer datapath. On the transmit side it takes a single memory request descriptor and serialises it, one doubleword per clock. The descriptor gives the direction, a 64-bit byte address, a length in doublewords, a tag, byte enables and a requester ID. The block picks the short three-doubleword header when the upper address half is zero and the long four-doubleword header otherwise. For a write, it pulls the payload doublewords from a data input immediately after the header.

On the receive side it watches a doubleword stream framed by start and end markers. When a completion arrives, the block decodes its header fields from fixed positions and reports them with a single pulse. It then forwards any data doublewords. Any other packet type is flagged as unsupported, and its remaining doublewords are discarded up to the end marker.

The transmit controller has six states. `TX_IDLE` goes to `TX_HDR1` when a request is accepted. The controller then steps through `TX_HDR1` and `TX_HDR2` to `TX_HDR3`. From `TX_HDR3` it goes to `TX_HDR4` for the long form, to `TX_PAY` for a short write, or back to `TX_IDLE` for a short read. From `TX_HDR4` it goes to `TX_PAY` for a write or to `TX_IDLE` for a read. `TX_PAY` returns to `TX_IDLE` after the last payload doubleword.

The receive controller has five states. `RX_IDLE` goes to `RX_CPL2` when a completion start arrives without an end marker. It goes to `RX_DROP` when any other start arrives without an end marker. `RX_CPL2` goes to `RX_CPL3`, or back to `RX_IDLE` if the packet is truncated. `RX_CPL3` goes to `RX_DATA` when the completion carries data, to `RX_DROP` when it does not, or to `RX_IDLE` on an end marker. `RX_DATA` and `RX_DROP` both return to `RX_IDLE` on an end marker.

Top module: `tlp_hdr_engine`

## Requirements
- R1: While reset is held and on the first cycle after release, `req_ready` is 1 and `tx_valid`, `cpl_hdr_valid`, `rx_data_valid` and `rx_unsup` are 0.
- R2: When `req_addr[63:32]` is zero, the header is three doublewords. Doubleword 1 carries format/type 0x00 for a read or 0x40 for a write in bits 31:24, the length in bits 9:0, and zero in all other bits.
- R3: When `req_addr[63:32]` is nonzero, the header is four doublewords. The format/type is 0x20 for a read or 0x60 for a write. Doubleword 3 carries `req_addr[63:32]` and doubleword 4 carries the low address.
- R4: Header doubleword 2 is requester ID in bits 31:16, tag in bits 15:8, last-doubleword byte enables in bits 7:4 and first-doubleword byte enables in bits 3:0.
- R5: The low-address doubleword always carries `req_addr[31:2]` in bits 31:2, with bits 1:0 forced to zero.
- R6: A write emits exactly as many payload doublewords as the length field gives, where 0 means 1024. Each payload cycle raises `wr_take` and passes `wr_data` to `tx_dw` in that same cycle. `tx_eop` marks the last payload doubleword of a write, or the last header doubleword of a read.
- R7: Doubleword 1, marked by `tx_sop`, appears in the cycle after the clock edge that accepts a request. Doublewords follow on consecutive cycles. `req_ready` is low until the cycle after the last doubleword.
- R8: A packet whose first doubleword has format/type 0x4a (with data) or 0x0a (without data) is a completion. One cycle after its third doubleword, `cpl_hdr_valid` pulses for one cycle. At that point the decoded fields are valid: completer ID from doubleword 2 bits 31:16, status from bits 15:13, byte count from bits 11:0, requester ID from doubleword 3 bits 31:16, tag from bits 15:8, lower address from bits 6:0, and length from doubleword 1 bits 9:0.
- R9: Each data doubleword of a completion with data appears on `rx_data` with `rx_data_valid` one cycle after it is received. `rx_data_last` is set for the doubleword that carried the end marker.
- R10: A start doubleword of any other format/type pulses `rx_unsup` one cycle later. The following doublewords up to and including the end marker produce no header or data output.
- R11: A completion that ends before its third doubleword produces no `cpl_hdr_valid` pulse. The next packet is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request descriptor present |
| req_ready | output | 1 | Transmit side idle, descriptor accepted this cycle |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_addr | input | 64 | Byte address |
| req_len | input | 10 | Length in doublewords, 0 = 1024 |
| req_tag | input | 8 | Transaction tag |
| req_be | input | 8 | Last enables [7:4], first enables [3:0] |
| req_rid | input | 16 | Requester ID |
| wr_data | input | 32 | Write payload doubleword |
| wr_take | output | 1 | Payload doubleword consumed this cycle |
| tx_valid | output | 1 | Outgoing doubleword valid |
| tx_sop | output | 1 | First doubleword of packet |
| tx_eop | output | 1 | Last doubleword of packet |
| tx_dw | output | 32 | Outgoing doubleword |
| rx_valid | input | 1 | Incoming doubleword valid |
| rx_sop | input | 1 | Incoming first doubleword |
| rx_eop | input | 1 | Incoming last doubleword |
| rx_dw | input | 32 | Incoming doubleword |
| cpl_hdr_valid | output | 1 | Completion header decoded (pulse) |
| cpl_cid | output | 16 | Completer ID |
| cpl_status | output | 3 | Completion status |
| cpl_bc | output | 12 | Byte count |
| cpl_rid | output | 16 | Requester ID of the completion |
| cpl_tag | output | 8 | Tag of the completion |
| cpl_laddr | output | 7 | Lower address |
| cpl_len | output | 10 | Length field of the completion |
| rx_data_valid | output | 1 | Completion data doubleword valid |
| rx_data | output | 32 | Completion data doubleword |
| rx_data_last | output | 1 | Last completion data doubleword |
| rx_unsup | output | 1 | Unsupported packet seen (pulse) |

## Verification
Transmit doublewords come from the state register alone, so header doubleword k is due k cycles after the accepting edge. Payload doublewords are combinational from `wr_data` in the payload cycle. The bench drives on the falling edge and samples on the next falling edge for header doublewords. For payload doublewords it samples one time step after changing `wr_data`. Every receive result is registered and appears one cycle after the doubleword that caused it, so the bench applies each incoming doubleword and checks the resulting outputs one full cycle later, before presenting the next doubleword.

// File: rtl/tlp_fmt_pkg.sv
package tlp_fmt_pkg;
    localparam int DW_W   = 32;
    localparam int ADDR_W = 64;
    localparam int LEN_W  = 10;
    localparam int TAG_W  = 8;
    localparam int BE_W   = 8;
    localparam int ID_W   = 16;
    localparam int BC_W   = 12;
    localparam int LA_W   = 7;
    localparam int ST_W   = 3;
    localparam int CNT_W  = LEN_W + 1;
    localparam int FT_W   = 8;
    localparam int PADW   = DW_W - FT_W - LEN_W;

    localparam logic [FT_W-1:0] FT_RD_S = 8'h00;
    localparam logic [FT_W-1:0] FT_RD_L = 8'h20;
    localparam logic [FT_W-1:0] FT_WR_S = 8'h40;
    localparam logic [FT_W-1:0] FT_WR_L = 8'h60;
    localparam logic [FT_W-1:0] FT_CPL  = 8'h0a;
    localparam logic [FT_W-1:0] FT_CPLD = 8'h4a;

    typedef enum logic [2:0] {
        TX_IDLE, TX_HDR1, TX_HDR2, TX_HDR3, TX_HDR4, TX_PAY
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_CPL2, RX_CPL3, RX_DATA, RX_DROP
    } rx_state_t;

    typedef struct packed {
        logic              wr;
        logic              wide;
        logic [ADDR_W-1:2] addr;
        logic [LEN_W-1:0]  len;
        logic [TAG_W-1:0]  tag;
        logic [BE_W-1:0]   be;
        logic [ID_W-1:0]   rid;
    } req_desc_t;

    function automatic logic [FT_W-1:0] pick_fmt(input logic wr, input logic wide);
        if (wr) return wide ? FT_WR_L : FT_WR_S;
        return wide ? FT_RD_L : FT_RD_S;
    endfunction
endpackage

// File: rtl/tlp_tx_fmt.sv
module tlp_tx_fmt
    import tlp_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [BE_W-1:0]   req_be,
    input  logic [ID_W-1:0]   req_rid,
    input  logic [DW_W-1:0]   wr_data,
    output logic              wr_take,
    output logic              tx_valid,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [DW_W-1:0]   tx_dw
);
    localparam logic [CNT_W-1:0] FULL_LEN = {1'b1, {LEN_W{1'b0}}};
    localparam logic [CNT_W-1:0] ONE_LEFT = {{(CNT_W-1){1'b0}}, 1'b1};

    tx_state_t        st_q, st_d;
    req_desc_t        d_q;
    logic [CNT_W-1:0] left_q;
    logic             accept;

    assign accept = req_valid && (st_q == TX_IDLE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE: if (req_valid) st_d = TX_HDR1;
            TX_HDR1: st_d = TX_HDR2;
            TX_HDR2: st_d = TX_HDR3;
            TX_HDR3: st_d = d_q.wide ? TX_HDR4 : (d_q.wr ? TX_PAY : TX_IDLE);
            TX_HDR4: st_d = d_q.wr ? TX_PAY : TX_IDLE;
            TX_PAY:  if (left_q == ONE_LEFT) st_d = TX_IDLE;
            default: st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q    <= '0;
            left_q <= '0;
        end else if (accept) begin
            d_q.wr   <= req_write;
            d_q.wide <= |req_addr[ADDR_W-1:32];
            d_q.addr <= req_addr[ADDR_W-1:2];
            d_q.len  <= req_len;
            d_q.tag  <= req_tag;
            d_q.be   <= req_be;
            d_q.rid  <= req_rid;
            left_q   <= (req_len == '0) ? FULL_LEN : {1'b0, req_len};
        end else if (st_q == TX_PAY) begin
            left_q <= left_q - ONE_LEFT;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        tx_valid  = 1'b0;
        tx_sop    = 1'b0;
        tx_eop    = 1'b0;
        tx_dw     = '0;
        wr_take   = 1'b0;
        unique case (st_q)
            TX_IDLE: req_ready = 1'b1;
            TX_HDR1: begin
                tx_valid = 1'b1;
                tx_sop   = 1'b1;
                tx_dw    = {pick_fmt(d_q.wr, d_q.wide), {PADW{1'b0}}, d_q.len};
            end
            TX_HDR2: begin
                tx_valid = 1'b1;
                tx_dw    = {d_q.rid, d_q.tag, d_q.be};
            end
            TX_HDR3: begin
                tx_valid = 1'b1;
                tx_dw    = d_q.wide ? d_q.addr[ADDR_W-1:32] : {d_q.addr[31:2], 2'b00};
                tx_eop   = !d_q.wide && !d_q.wr;
            end
            TX_HDR4: begin
                tx_valid = 1'b1;
                tx_dw    = {d_q.addr[31:2], 2'b00};
                tx_eop   = !d_q.wr;
            end
            TX_PAY: begin
                tx_valid = 1'b1;
                wr_take  = 1'b1;
                tx_dw    = wr_data;
                tx_eop   = (left_q == ONE_LEFT);
            end
            default: req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlp_rx_parse.sv
module tlp_rx_parse
    import tlp_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sop,
    input  logic             rx_eop,
    input  logic [DW_W-1:0]  rx_dw,
    output logic             cpl_hdr_valid,
    output logic [ID_W-1:0]  cpl_cid,
    output logic [ST_W-1:0]  cpl_status,
    output logic [BC_W-1:0]  cpl_bc,
    output logic [ID_W-1:0]  cpl_rid,
    output logic [TAG_W-1:0] cpl_tag,
    output logic [LA_W-1:0]  cpl_laddr,
    output logic [LEN_W-1:0] cpl_len,
    output logic             rx_data_valid,
    output logic [DW_W-1:0]  rx_data,
    output logic             rx_data_last,
    output logic             rx_unsup
);
    rx_state_t st_q, st_d;
    logic      has_data_q;
    logic      is_cpl;
    logic      start;

    assign start  = rx_valid && rx_sop;
    assign is_cpl = (rx_dw[DW_W-1 -: FT_W] == FT_CPL) || (rx_dw[DW_W-1 -: FT_W] == FT_CPLD);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE: if (start && !rx_eop) st_d = is_cpl ? RX_CPL2 : RX_DROP;
            RX_CPL2: if (rx_valid) st_d = rx_eop ? RX_IDLE : RX_CPL3;
            RX_CPL3: if (rx_valid) st_d = rx_eop ? RX_IDLE : (has_data_q ? RX_DATA : RX_DROP);
            RX_DATA: if (rx_valid && rx_eop) st_d = RX_IDLE;
            RX_DROP: if (rx_valid && rx_eop) st_d = RX_IDLE;
            default: st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_data_q    <= 1'b0;
            cpl_hdr_valid <= 1'b0;
            cpl_cid       <= '0;
            cpl_status    <= '0;
            cpl_bc        <= '0;
            cpl_rid       <= '0;
            cpl_tag       <= '0;
            cpl_laddr     <= '0;
            cpl_len       <= '0;
            rx_data_valid <= 1'b0;
            rx_data       <= '0;
            rx_data_last  <= 1'b0;
            rx_unsup      <= 1'b0;
        end else begin
            cpl_hdr_valid <= 1'b0;
            rx_data_valid <= 1'b0;
            rx_data_last  <= 1'b0;
            rx_unsup      <= 1'b0;
            if (rx_valid) begin
                unique case (st_q)
                    RX_IDLE: if (rx_sop) begin
                        if (is_cpl) begin
                            has_data_q <= rx_dw[30];
                            cpl_len    <= rx_dw[LEN_W-1:0];
                        end else begin
                            rx_unsup <= 1'b1;
                        end
                    end
                    RX_CPL2: begin
                        cpl_cid    <= rx_dw[31:16];
                        cpl_status <= rx_dw[15:13];
                        cpl_bc     <= rx_dw[BC_W-1:0];
                    end
                    RX_CPL3: begin
                        cpl_rid       <= rx_dw[31:16];
                        cpl_tag       <= rx_dw[15:8];
                        cpl_laddr     <= rx_dw[LA_W-1:0];
                        cpl_hdr_valid <= 1'b1;
                    end
                    RX_DATA: begin
                        rx_data_valid <= 1'b1;
                        rx_data       <= rx_dw;
                        rx_data_last  <= rx_eop;
                    end
                    RX_DROP: rx_data_last <= 1'b0;
                    default: rx_data_last <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tlp_hdr_engine.sv
module tlp_hdr_engine
    import tlp_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [BE_W-1:0]   req_be,
    input  logic [ID_W-1:0]   req_rid,
    input  logic [DW_W-1:0]   wr_data,
    output logic              wr_take,
    output logic              tx_valid,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [DW_W-1:0]   tx_dw,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [DW_W-1:0]   rx_dw,
    output logic              cpl_hdr_valid,
    output logic [ID_W-1:0]   cpl_cid,
    output logic [ST_W-1:0]   cpl_status,
    output logic [BC_W-1:0]   cpl_bc,
    output logic [ID_W-1:0]   cpl_rid,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [LA_W-1:0]   cpl_laddr,
    output logic [LEN_W-1:0]  cpl_len,
    output logic              rx_data_valid,
    output logic [DW_W-1:0]   rx_data,
    output logic              rx_data_last,
    output logic              rx_unsup
);
    tlp_tx_fmt tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_tag   (req_tag),
        .req_be    (req_be),
        .req_rid   (req_rid),
        .wr_data   (wr_data),
        .wr_take   (wr_take),
        .tx_valid  (tx_valid),
        .tx_sop    (tx_sop),
        .tx_eop    (tx_eop),
        .tx_dw     (tx_dw)
    );

    tlp_rx_parse rx_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_sop        (rx_sop),
        .rx_eop        (rx_eop),
        .rx_dw         (rx_dw),
        .cpl_hdr_valid (cpl_hdr_valid),
        .cpl_cid       (cpl_cid),
        .cpl_status    (cpl_status),
        .cpl_bc        (cpl_bc),
        .cpl_rid       (cpl_rid),
        .cpl_tag       (cpl_tag),
        .cpl_laddr     (cpl_laddr),
        .cpl_len       (cpl_len),
        .rx_data_valid (rx_data_valid),
        .rx_data       (rx_data),
        .rx_data_last  (rx_data_last),
        .rx_unsup      (rx_unsup)
    );
endmodule

// File: rtl/tlp_hdr_engine_chk.sv
module tlp_hdr_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic wr_take,
    input logic tx_valid,
    input logic tx_sop,
    input logic tx_eop,
    input logic rx_valid,
    input logic cpl_hdr_valid,
    input logic rx_data_valid,
    input logic rx_unsup
);
    // R7
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !tx_valid);
    // R7
    accept_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> tx_sop);
    // R7
    sop_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sop |=> (tx_valid && !tx_sop && !tx_eop));
    // R6
    take_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (tx_valid && !tx_sop));
    // R6
    eop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eop |-> tx_valid);
    // R8
    hdr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_hdr_valid |=> !cpl_hdr_valid);
    // R8
    hdr_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_hdr_valid |-> $past(rx_valid));
    // R9
    data_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_valid |-> $past(rx_valid));
    // R10
    unsup_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_unsup |-> (!cpl_hdr_valid && !rx_data_valid));
endmodule

bind tlp_hdr_engine tlp_hdr_engine_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .wr_take       (wr_take),
    .tx_valid      (tx_valid),
    .tx_sop        (tx_sop),
    .tx_eop        (tx_eop),
    .rx_valid      (rx_valid),
    .cpl_hdr_valid (cpl_hdr_valid),
    .rx_data_valid (rx_data_valid),
    .rx_unsup      (rx_unsup)
);

// File: tb/tlp_hdr_engine_tb_top.sv
module tlp_hdr_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [63:0] req_addr = '0;
    logic [9:0]  req_len = '0;
    logic [7:0]  req_tag = '0;
    logic [7:0]  req_be = '0;
    logic [15:0] req_rid = '0;
    logic [31:0] wr_data = '0;
    logic        wr_take;
    logic        tx_valid, tx_sop, tx_eop;
    logic [31:0] tx_dw;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [31:0] rx_dw = '0;
    logic        cpl_hdr_valid;
    logic [15:0] cpl_cid, cpl_rid;
    logic [2:0]  cpl_status;
    logic [11:0] cpl_bc;
    logic [7:0]  cpl_tag;
    logic [6:0]  cpl_laddr;
    logic [9:0]  cpl_len;
    logic        rx_data_valid, rx_data_last, rx_unsup;
    logic [31:0] rx_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tlp_hdr_engine dut_i (.*);

    typedef struct packed {
        logic        wr;
        logic [63:0] addr;
        logic [9:0]  len;
        logic [7:0]  tag;
        logic [7:0]  be;
        logic [15:0] rid;
        logic [31:0] e1;
        logic [31:0] e3;
        logic [31:0] e4;
        logic        wide;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{1'b0, 64'h0000_0000_1234_5678, 10'd4, 8'h11, 8'hFF, 16'h0100,
          32'h0000_0004, 32'h1234_5678, 32'h0, 1'b0},
        '{1'b1, 64'h0000_0000_8000_0003, 10'd2, 8'h22, 8'h0F, 16'h0203,
          32'h4000_0002, 32'h8000_0000, 32'h0, 1'b0},
        '{1'b0, 64'h0000_0001_0000_0040, 10'd0, 8'h33, 8'h3C, 16'hBEEF,
          32'h2000_0000, 32'h0000_0001, 32'h0000_0040, 1'b1},
        '{1'b1, 64'hFFFF_0000_0000_1006, 10'd3, 8'hFE, 8'hF1, 16'h0A05,
          32'h6000_0003, 32'hFFFF_0000, 32'h0000_1004, 1'b1},
        '{1'b1, 64'h0000_0000_FFFF_FFFC, 10'd1, 8'h00, 8'h01, 16'hFFFF,
          32'h4000_0001, 32'hFFFF_FFFC, 32'h0, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_tx(input vec_t v);
        logic [31:0] eh [4];
        int nh;
        int np;
        nh = v.wide ? 4 : 3;
        np = (v.len == 10'd0) ? 1024 : int'(v.len);
        eh[0] = v.e1;
        eh[1] = {v.rid, v.tag, v.be};
        eh[2] = v.e3;
        eh[3] = v.e4;
        chk("R7 ready before accept", req_ready, 1);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_len = v.len; req_tag = v.tag; req_be = v.be; req_rid = v.rid;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < nh; i++) begin
            chk("R7 valid/sop", {tx_valid, tx_sop}, {1'b1, i == 0});
            chk("R7 ready low in packet", req_ready, 0);
            chk("R6 header eop", tx_eop, (!v.wr && i == nh - 1));
            if (i == 0)      chk(v.wide ? "R3 dw1" : "R2 dw1", tx_dw, eh[0]);
            else if (i == 1) chk("R4 dw2", tx_dw, eh[1]);
            else             chk(v.wide ? "R3 R5 addr dw" : "R5 addr dw", tx_dw, eh[i]);
            @(negedge clk);
        end
        if (v.wr) begin
            for (int p = 0; p < np; p++) begin
                wr_data = 32'hA500_0000 + p;
                #1;
                chk("R6 payload", {tx_valid, wr_take, tx_eop, tx_dw},
                    {1'b1, 1'b1, p == np - 1, 32'hA500_0000 + p});
                @(negedge clk);
            end
        end
        chk("R7 idle after packet", {tx_valid, req_ready}, 2'b01);
    endtask

    task automatic rx_beat(input logic s, input logic e, input logic [31:0] d);
        rx_valid = 1'b1; rx_sop = s; rx_eop = e; rx_dw = d;
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 reset outputs", {req_ready, tx_valid, cpl_hdr_valid, rx_data_valid, rx_unsup}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {req_ready, tx_valid, cpl_hdr_valid, rx_data_valid, rx_unsup}, 5'b10000);

        for (int k = 0; k < 5; k++) begin
            run_tx(VEC[k]);
            @(negedge clk);
        end

        // R6 length 0 means 1024 payload doublewords
        run_tx('{1'b1, 64'h40, 10'd0, 8'h5A, 8'hFF, 16'h1234,
                 32'h4000_0000, 32'h40, 32'h0, 1'b0});
        @(negedge clk);

        // R8 R9 completion with data, two data doublewords
        rx_beat(1'b1, 1'b0, 32'h4a00_0002);
        chk("R8 no early hdr", cpl_hdr_valid, 0);
        rx_beat(1'b0, 1'b0, 32'h0200_0008);
        chk("R8 no early hdr", cpl_hdr_valid, 0);
        rx_beat(1'b0, 1'b0, 32'h0100_1124);
        chk("R8 hdr valid", cpl_hdr_valid, 1);
        chk("R8 fields", {cpl_cid, cpl_status, cpl_bc, cpl_rid, cpl_tag, cpl_laddr, cpl_len},
            {16'h0200, 3'd0, 12'h008, 16'h0100, 8'h11, 7'h24, 10'd2});
        rx_beat(1'b0, 1'b0, 32'hCAFE_0001);
        chk("R9 data 1", {rx_data_valid, rx_data_last, rx_data}, {2'b10, 32'hCAFE_0001});
        chk("R8 hdr pulse single", cpl_hdr_valid, 0);
        rx_beat(1'b0, 1'b1, 32'hCAFE_0002);
        chk("R9 data 2 last", {rx_data_valid, rx_data_last, rx_data}, {2'b11, 32'hCAFE_0002});
        @(negedge clk);
        chk("R9 idle", rx_data_valid, 0);

        // R8 completion without data, status field nonzero
        rx_beat(1'b1, 1'b0, 32'h0a00_0000);
        rx_beat(1'b0, 1'b0, 32'h0300_2004);
        rx_beat(1'b0, 1'b1, 32'h0100_7F05);
        chk("R8 nodata hdr", {cpl_hdr_valid, cpl_cid, cpl_status, cpl_bc, cpl_rid, cpl_tag, cpl_laddr},
            {1'b1, 16'h0300, 3'd1, 12'h004, 16'h0100, 8'h7F, 7'h05});
        chk("R8 nodata no data", rx_data_valid, 0);
        @(negedge clk);

        // R10 memory write packet is not a completion
        rx_beat(1'b1, 1'b0, 32'h4000_0001);
        chk("R10 unsup flag", {rx_unsup, cpl_hdr_valid}, 2'b10);
        rx_beat(1'b0, 1'b0, 32'h0100_11FF);
        chk("R10 dropped", {rx_unsup, cpl_hdr_valid, rx_data_valid}, 3'b000);
        rx_beat(1'b0, 1'b0, 32'h0100_1124);
        chk("R10 dropped", {cpl_hdr_valid, rx_data_valid}, 2'b00);
        rx_beat(1'b0, 1'b1, 32'hDEAD_BEEF);
        chk("R10 dropped", {cpl_hdr_valid, rx_data_valid}, 2'b00);
        // R10 single-doubleword read packet
        rx_beat(1'b1, 1'b1, 32'h0000_0001);
        chk("R10 single unsup", rx_unsup, 1);
        @(negedge clk);

        // R11 truncated completion, then a good one
        rx_beat(1'b1, 1'b0, 32'h4a00_0001);
        rx_beat(1'b0, 1'b1, 32'h0200_0004);
        chk("R11 no hdr", cpl_hdr_valid, 0);
        @(negedge clk);
        chk("R11 no hdr", cpl_hdr_valid, 0);
        rx_beat(1'b1, 1'b0, 32'h4a00_0001);
        chk("R11 recovered no unsup", rx_unsup, 0);
        rx_beat(1'b0, 1'b0, 32'h0400_0004);
        rx_beat(1'b0, 1'b0, 32'h0100_4208);
        chk("R11 recovered hdr", {cpl_hdr_valid, cpl_cid, cpl_tag, cpl_laddr},
            {1'b1, 16'h0400, 8'h42, 7'h08});
        rx_beat(1'b0, 1'b1, 32'h1111_2222);
        chk("R9 recovered data", {rx_data_valid, rx_data_last, rx_data}, {2'b11, 32'h1111_2222});
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule